// File: doc/BRIEF.md
# Sparse Column Run-Length Encoder

This block compresses a stream of dense matrix columns, one element per cycle, into a compact sparse form. Each element is a 4-bit index into a shared weight codebook, and index 0 means the weight is zero. Every nonzero element that the block keeps becomes one 8-bit entry. The entry holds the index together with the number of kept zeros that came just before it in the same column. When a run of zeros is too long for the 4-bit count, the block splits it with padding entries whose index is zero. The entries of all columns are written to one contiguous entry store through a simple write port.

At the last element of each column, the block writes a 16-bit pointer to a second store. The pointer gives the address just past that column's last entry. Pointer index 0 holds 0, and reset writes it. The pointer array therefore has one more slot than there are columns. The entry count of column j, padding included, is p[j+1] - p[j].

Rows can be split across N processing lanes. The block then keeps only the rows whose position in the column, taken modulo N, equals the selected lane number. Zero runs count only the kept rows. Outputs appear one clock after the element that causes them.

Top module: `spcol_rle_enc`

## Requirements
- R1: A kept nonzero element produces one entry write with the element's index in bits 7:4 and, in bits 3:0, the number of kept zeros since the previous entry of the column or since the column start.
- R2: When a kept zero arrives and the run count already stands at 15, the block writes a padding entry with index 0 and count 15 (byte 0x0F), and the run count restarts at 0. The column 0,0,1,2, then 18 zeros, then 3 encodes as the bytes 0x12, 0x20, 0x0F, 0x32.
- R3: Zeros at the end of a column produce no entry, apart from the padding entries already due under R2. The run count restarts at every element flagged as a column start, so no run carries over into the next column.
- R4: With cfg_lanes = N of 2 or more, only rows r with r mod N = cfg_lane are kept. The row number r counts from 0 at the column start. A cfg_lanes value of 0 or 1 keeps every row. Rows that are not kept neither write entries nor add to the zero run.
- R5: Entry writes use consecutive addresses that start at 0 after reset and continue across column boundaries without gaps.
- R6: The last element of column j produces a pointer write to index j+1 whose data is the address one past the column's final entry, counting an entry written in that same cycle. Columns are numbered from 0 after reset.
- R7: While reset is asserted, the block writes no entry and overflow is low, and the pointer port writes 0 to index 0.
- R8: If an entry is due while the next address is 2^PTR_W - 1, the block does not write it and sets overflow. Overflow then stays set until reset, and no further entry or pointer writes occur.
- R9: A cycle with in_valid low changes no state and writes nothing, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Element present this cycle |
| in_first | input | 1 | Element is the first row of a column |
| in_last | input | 1 | Element is the last row of a column |
| in_idx | input | 4 | Codebook index, 0 for a zero weight |
| cfg_lanes | input | LANE_W | Number of lanes N (0 or 1 keeps all rows) |
| cfg_lane | input | LANE_W | Lane whose rows are kept |
| ent_we | output | 1 | Entry write strobe |
| ent_addr | output | PTR_W | Entry write address |
| ent_data | output | 8 | Entry byte: index in bits 7:4, zero count in bits 3:0 |
| ptr_we | output | 1 | Pointer write strobe |
| ptr_addr | output | COL_W | Pointer array index |
| ptr_data | output | PTR_W | Pointer value |
| overflow | output | 1 | Entry address range exhausted (sticky) |

## Verification
The hardest case to reach from the ports is overflow. It needs the entry address to climb to its last value, which takes tens of thousands of kept nonzero elements. The bench feeds one very long all-nonzero column, checks the final legal write at address 0xFFFE, and then checks that the next entry is dropped, that the flag rises, and that the closing pointer write is suppressed. The padding boundary is also targeted directly. Runs of exactly 15, 16 and 18 zeros are sent, some at a column end and one broken by idle cycles that carry nonzero indices, along with lane settings where the kept rows fall on zeros.

// File: rtl/sce_pkg.sv
package sce_pkg;
  localparam int NIB_W = 4;
  localparam int ENT_W = 2 * NIB_W;
  localparam logic [NIB_W-1:0] RUN_MAX = '1;

  // Entry byte: codebook index in the upper nibble, preceding zero count below
  function automatic logic [ENT_W-1:0] pack_entry(input logic [NIB_W-1:0] val,
                                                  input logic [NIB_W-1:0] run);
    return {val, run};
  endfunction
endpackage

// File: rtl/sce_lane_sel.sv
module sce_lane_sel #(
  parameter int LANE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [LANE_W-1:0] cfg_lanes,
  input  logic [LANE_W-1:0] cfg_lane,
  output logic              keep
);
  logic [LANE_W-1:0] phase_q;
  logic [LANE_W-1:0] phase_cur;

  // Row position modulo N, kept as a wrapping counter rather than a divider
  function automatic logic [LANE_W-1:0] phase_step(input logic [LANE_W-1:0] cur,
                                                   input logic [LANE_W-1:0] n);
    if (n <= LANE_W'(1))           return '0;
    else if (cur >= n - LANE_W'(1)) return '0;
    else                            return cur + LANE_W'(1);
  endfunction

  assign phase_cur = in_first ? '0 : phase_q;
  assign keep      = in_valid && ((cfg_lanes <= LANE_W'(1)) || (phase_cur == cfg_lane));

  always_ff @(posedge clk) begin
    if (!rst_n)        phase_q <= '0;
    else if (in_valid) phase_q <= phase_step(phase_cur, cfg_lanes);
  end

  // R4: row 0 of a column belongs to lane 0 only
  assert_lane_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first && cfg_lanes > LANE_W'(1) && cfg_lane != '0) |-> !keep);
  // R9: idle cycles leave the row position untouched
  assert_lane_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(phase_q));
endmodule

// File: rtl/sce_run_track.sv
module sce_run_track
  import sce_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             keep,
  input  logic             in_first,
  input  logic [NIB_W-1:0] in_idx,
  output logic             emit,
  output logic [NIB_W-1:0] emit_val,
  output logic [NIB_W-1:0] emit_run,
  output logic             pad_evt
);
  logic [NIB_W-1:0] run_q, run_cur, run_nxt;

  assign run_cur = in_first ? '0 : run_q;

  always_comb begin
    emit     = 1'b0;
    pad_evt  = 1'b0;
    emit_val = in_idx;
    emit_run = run_cur;
    run_nxt  = run_cur;
    if (keep) begin
      if (in_idx != '0) begin
        emit    = 1'b1;
        run_nxt = '0;
      end else if (run_cur == RUN_MAX) begin
        emit     = 1'b1;
        pad_evt  = 1'b1;
        emit_val = '0;
        run_nxt  = '0;
      end else begin
        run_nxt = run_cur + NIB_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= '0;
    else if (in_valid) run_q <= run_nxt;
  end

  // R3: a nonzero on the first row of a column always reports a zero run
  assert_first_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (keep && in_first && in_idx != '0) |-> (emit && emit_run == '0));
  // R9: idle cycles leave the run count untouched
  assert_run_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(run_q));
  // R2: a padding event restarts the run
  assert_pad_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pad_evt |=> run_q == '0);
endmodule

// File: rtl/sce_addr_ctrl.sv
module sce_addr_ctrl
  import sce_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int COL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             emit,
  input  logic [NIB_W-1:0] emit_val,
  input  logic [NIB_W-1:0] emit_run,
  output logic             ent_we,
  output logic [PTR_W-1:0] ent_addr,
  output logic [ENT_W-1:0] ent_data,
  output logic             ptr_we,
  output logic [COL_W-1:0] ptr_addr,
  output logic [PTR_W-1:0] ptr_data,
  output logic             overflow
);
  localparam logic [PTR_W-1:0] ADDR_LAST = '1;

  logic [PTR_W-1:0] addr_q, end_addr;
  logic [COL_W-1:0] col_q;
  logic             room, do_write, hit_ovf, ptr_evt;

  assign room     = (addr_q != ADDR_LAST);
  assign do_write = emit && !overflow && room;
  assign hit_ovf  = emit && !overflow && !room;
  assign ptr_evt  = in_valid && in_last && !overflow && !hit_ovf;
  assign end_addr = addr_q + PTR_W'(do_write);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_we   <= 1'b0;
      ent_addr <= '0;
      ent_data <= '0;
      ptr_we   <= 1'b1;   // slot 0 of the pointer array is written during reset
      ptr_addr <= '0;
      ptr_data <= '0;
      addr_q   <= '0;
      col_q    <= '0;
      overflow <= 1'b0;
    end else begin
      ent_we <= do_write;
      ptr_we <= ptr_evt;
      if (do_write) begin
        ent_addr <= addr_q;
        ent_data <= pack_entry(emit_val, emit_run);
      end
      addr_q <= end_addr;
      if (ptr_evt) begin
        ptr_addr <= col_q + COL_W'(1);
        ptr_data <= end_addr;
      end
      if (in_valid && in_last) col_q <= col_q + COL_W'(1);
      if (hit_ovf) overflow <= 1'b1;
    end
  end

  // R5: back-to-back entry writes land on consecutive addresses
  assert_addr_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_we ##1 ent_we) |-> ent_addr == $past(ent_addr) + PTR_W'(1));
  // R6: a pointer written with an entry points just past that entry
  assert_ptr_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && ent_we) |-> ptr_data == ent_addr + PTR_W'(1));
  // R8: overflow is sticky
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R8: nothing is written once overflow is set
  assert_no_overflow_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (!ent_we && !ptr_we));
endmodule

// File: rtl/spcol_rle_enc.sv
module spcol_rle_enc
  import sce_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int COL_W  = 12,
  parameter int LANE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [3:0]        in_idx,
  input  logic [LANE_W-1:0] cfg_lanes,
  input  logic [LANE_W-1:0] cfg_lane,
  output logic              ent_we,
  output logic [PTR_W-1:0]  ent_addr,
  output logic [7:0]        ent_data,
  output logic              ptr_we,
  output logic [COL_W-1:0]  ptr_addr,
  output logic [PTR_W-1:0]  ptr_data,
  output logic              overflow
);
  logic             keep;
  logic             emit, pad_evt;
  logic [NIB_W-1:0] emit_val, emit_run;

  sce_lane_sel #(.LANE_W(LANE_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .cfg_lanes(cfg_lanes), .cfg_lane(cfg_lane), .keep(keep)
  );

  sce_run_track u_run (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .keep(keep),
    .in_first(in_first), .in_idx(in_idx), .emit(emit),
    .emit_val(emit_val), .emit_run(emit_run), .pad_evt(pad_evt)
  );

  sce_addr_ctrl #(.PTR_W(PTR_W), .COL_W(COL_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .emit(emit), .emit_val(emit_val), .emit_run(emit_run),
    .ent_we(ent_we), .ent_addr(ent_addr), .ent_data(ent_data),
    .ptr_we(ptr_we), .ptr_addr(ptr_addr), .ptr_data(ptr_data),
    .overflow(overflow)
  );

  // R2: an entry with index 0 is always a full-length padding entry
  assert_pad_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_we && ent_data[7:4] == 4'h0) |-> ent_data[3:0] == 4'hF);
  // R2: every padding event reaches the entry port one cycle later unless overflowed
  assert_pad_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_evt && !overflow) |=> (overflow || (ent_we && ent_data == 8'h0F)));
  // R7: reset state of the write ports
  assert_reset_state_R7: assert property (@(posedge clk)
    !rst_n |=> (!ent_we && !overflow && ptr_we && ptr_addr == '0 && ptr_data == '0));
endmodule

// File: tb/spcol_rle_enc_bench.sv
module spcol_rle_enc_bench;
  localparam int PTR_W = 16, COL_W = 12, LANE_W = 4;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [3:0]        in_idx = '0;
  logic [LANE_W-1:0] cfg_lanes = 4'd1, cfg_lane = '0;
  logic              ent_we, ptr_we, overflow;
  logic [PTR_W-1:0]  ent_addr, ptr_data;
  logic [7:0]        ent_data;
  logic [COL_W-1:0]  ptr_addr;

  int vectors = 0, miscompares = 0;
  int exp_addr = 0, exp_col = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spcol_rle_enc #(.PTR_W(PTR_W), .COL_W(COL_W), .LANE_W(LANE_W)) u_spcol_rle_enc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_idx(in_idx), .cfg_lanes(cfg_lanes), .cfg_lane(cfg_lane),
    .ent_we(ent_we), .ent_addr(ent_addr), .ent_data(ent_data),
    .ptr_we(ptr_we), .ptr_addr(ptr_addr), .ptr_data(ptr_data), .overflow(overflow)
  );

  // {first, last, idx[3:0], exp_we, exp_data[7:0], exp_ptr_we}
  localparam logic [15:0] VEC [15] = '{
    {1'b1,1'b0,4'h5,1'b1,8'h50,1'b0},
    {1'b0,1'b0,4'h0,1'b0,8'h00,1'b0},
    {1'b0,1'b0,4'h0,1'b0,8'h00,1'b0},
    {1'b0,1'b0,4'h7,1'b1,8'h72,1'b0},
    {1'b0,1'b1,4'h0,1'b0,8'h00,1'b1},
    {1'b1,1'b1,4'h9,1'b1,8'h90,1'b1},
    {1'b1,1'b0,4'h0,1'b0,8'h00,1'b0},
    {1'b0,1'b0,4'h0,1'b0,8'h00,1'b0},
    {1'b0,1'b0,4'h0,1'b0,8'h00,1'b0},
    {1'b0,1'b1,4'hF,1'b1,8'hF3,1'b1},
    {1'b1,1'b0,4'h0,1'b0,8'h00,1'b0},
    {1'b0,1'b0,4'h0,1'b0,8'h00,1'b0},
    {1'b0,1'b1,4'h0,1'b0,8'h00,1'b1},
    {1'b1,1'b0,4'h0,1'b0,8'h00,1'b0},
    {1'b0,1'b1,4'h4,1'b1,8'h41,1'b1}
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic f, input logic l, input logic [3:0] idx,
                       input logic ewe, input logic [7:0] ed, input logic pwe,
                       input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_first = f; in_last = l; in_idx = idx;
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk(ent_we == ewe, tag, "ent_we", ent_we, ewe);
    if (ewe) begin
      chk(ent_data == ed, tag, "ent_data", ent_data, ed);
      chk(ent_addr == PTR_W'(exp_addr), tag, "ent_addr", ent_addr, exp_addr);
      exp_addr++;
    end
    chk(ptr_we == pwe, tag, "ptr_we", ptr_we, pwe);
    if (pwe) begin
      chk(ptr_addr == COL_W'(exp_col + 1), tag, "ptr_addr", ptr_addr, exp_col + 1);
      chk(ptr_data == PTR_W'(exp_addr), tag, "ptr_data", ptr_data, exp_addr);
    end
    if (l) exp_col++;
  endtask

  task automatic idle(input logic [3:0] idx);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b1; in_last = 1'b1; in_idx = idx;
    @(posedge clk); #1;
    chk(!ent_we && !ptr_we, "R9", "idle write", {ent_we, ptr_we}, 0);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(ent_we == 1'b0, "R7", "ent_we in reset", ent_we, 0);
    chk(overflow == 1'b0, "R7", "overflow in reset", overflow, 0);
    chk(ptr_we && ptr_addr == '0 && ptr_data == '0, "R7", "ptr slot0 write",
        {ptr_we, ptr_addr, ptr_data}, {1'b1, 28'h0});
    @(negedge clk);
    rst_n = 1'b1;
    exp_addr = 0; exp_col = 0;
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    do_reset();

    // Table walk: R1 packing, R3 trailing zeros and run restart, R5 addresses, R6 pointers
    foreach (VEC[k]) begin
      apply(VEC[k][15], VEC[k][14], VEC[k][13:10], VEC[k][9], VEC[k][8:1], VEC[k][0],
            "R1 R3 R5 R6 table");
    end

    // R2 worked column: 0,0,1,2, 18 zeros, 3 with idle cycles (R9) in the run
    for (int e = 0; e < 23; e++) begin
      logic [3:0] v;
      v = (e == 2) ? 4'h1 : (e == 3) ? 4'h2 : (e == 22) ? 4'h3 : 4'h0;
      if (e == 10) begin idle(4'h7); idle(4'h0); end
      apply(e == 0, e == 22, v, (e == 2 || e == 3 || e == 19 || e == 22),
            (e == 2) ? 8'h12 : (e == 3) ? 8'h20 : (e == 19) ? 8'h0F : 8'h32,
            e == 22, "R2");
    end
    // R2 boundary: 15 zeros then a nonzero gives count 15 and no padding
    for (int e = 0; e < 16; e++)
      apply(e == 0, e == 15, (e == 15) ? 4'hA : 4'h0, e == 15, 8'hAF, e == 15, "R2");
    // R3: 17 trailing zeros give one padding entry, nothing for the 17th
    for (int e = 0; e < 17; e++)
      apply(e == 0, e == 16, 4'h0, e == 15, 8'h0F, e == 16, "R3");

    // R4: four lanes, lane 2 keeps rows 2,6,10 (values 0,0,3)
    cfg_lanes = 4'd4; cfg_lane = 4'd2;
    for (int r = 0; r < 12; r++) begin
      logic [3:0] v;
      v = (r % 4 == 2) ? ((r == 10) ? 4'h3 : 4'h0) : 4'(r + 1);
      apply(r == 0, r == 11, v, r == 10, 8'h32, r == 11, "R4");
    end
    // R4: lane 1 keeps rows 1,5,9 with values 2,6,10
    cfg_lane = 4'd1;
    for (int r = 0; r < 12; r++)
      apply(r == 0, r == 11, 4'(r + 1), (r % 4 == 1), {4'(r + 1), 4'h0}, r == 11, "R4");
    // R4: lane number outside N keeps nothing
    cfg_lanes = 4'd2; cfg_lane = 4'd3;
    apply(1'b1, 1'b0, 4'h5, 1'b0, 8'h00, 1'b0, "R4");
    apply(1'b0, 1'b1, 4'h6, 1'b0, 8'h00, 1'b1, "R4");
    // R4: N = 0 keeps every row
    cfg_lanes = 4'd0; cfg_lane = 4'd0;
    apply(1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 1'b0, "R4");
    apply(1'b0, 1'b1, 4'h8, 1'b1, 8'h81, 1'b1, "R4");

    // R8: exhaust the entry address range with one long nonzero column
    cfg_lanes = 4'd1;
    do_reset();
    @(negedge clk);
    in_valid = 1'b1; in_first = 1'b1; in_last = 1'b0; in_idx = 4'h6;
    for (int k = 0; k < 65535; k++) begin
      @(posedge clk); #1;
      in_first = 1'b0;
      if (k == 0)
        chk(ent_we && ent_addr == 16'h0000, "R5", "first long entry", ent_addr, 0);
      if (k == 65534) begin
        chk(ent_we && ent_addr == 16'hFFFE && !overflow, "R8", "last legal write",
            {ent_we, ent_addr, overflow}, {1'b1, 16'hFFFE, 1'b0});
      end
    end
    @(posedge clk); #1;
    chk(!ent_we && overflow, "R8", "dropped entry", {ent_we, overflow}, 2'b01);
    @(negedge clk);
    in_last = 1'b1; in_idx = 4'h2;
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk(!ent_we && !ptr_we && overflow, "R8", "no write after overflow",
        {ent_we, ptr_we, overflow}, 3'b001);
    do_reset();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule